// File: doc/BRIEF.md
# Two-Cycle Memory Bus Sequencer

This block is the bus master of a small 8-bit processor-style system with a 16-bit address space. A client presents an address, a write byte and a direction flag on a request port. The sequencer then runs one fixed two-clock access on a modelled external bus.

During that access it drives the address, active-low read and write strobes, an output enable for its data lines and the outgoing byte. It finishes with a one-cycle done pulse. On reads, that pulse comes with the byte it sampled. It also decodes the upper four address bits into an active-low select for a single 4 KiB memory window.

Reads sample the incoming data lines on the falling clock edge inside the second period. Writes start driving data, and pull the write strobe low, at the rising edge that opens the second period.

Top module: `bus_seq_top`

## Requirements
- R1: While reset is high at a rising edge, and after it, `bus_rd_n`, `bus_wr_n` and `bus_cs_n` are 1, and `bus_oe`, `busy` and `done` are 0.
- R2: A request (`req_valid` = 1) is taken only at a rising edge where `busy` = 0. A request raised while `busy` = 1 is dropped: the bus address and strobes of the running access are unchanged, and no further access follows.
- R3: The address of an accepted request appears on `bus_addr` from the rising edge that opens period 1. It stays unchanged through period 2. `busy` is 1 for exactly these two periods.
- R4: In a read, `bus_rd_n` is 1 during period 1 and 0 during period 2, and `bus_oe` stays 0 for the whole access.
- R5: In a read, `rd_data` presents the value that `bus_din` held at the falling clock edge within period 2. Values held before or after that edge have no effect.
- R6: In a write, period 1 has `bus_wr_n` = 1 and `bus_oe` = 0. Period 2 has `bus_wr_n` = 0, `bus_oe` = 1 and `bus_dout` equal to the request's write byte.
- R7: `bus_rd_n` and `bus_wr_n` are never 0 together. Both are 1 once period 2 ends.
- R8: `bus_cs_n` is 0 during an access only when address bits [15:12] equal 4'b0001, that is 0x1000 to 0x1FFF. It is 1 otherwise, and 1 when idle.
- R9: `done` is 1 for exactly the one cycle after period 2, and `busy` is 0 in that cycle.
- R10: An access outside the window runs the same two-period sequence with `bus_cs_n` held at 1. A read there still returns the sampled `bus_din` value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising edges step the access, the falling edge samples read data |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Byte to write |
| req_write | input | 1 | 1 = write, 0 = read |
| busy | output | 1 | High during both bus periods |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte captured by the last read |
| bus_addr | output | 16 | External address lines |
| bus_din | input | 8 | External data lines as seen by the master |
| bus_dout | output | 8 | Byte the master drives when enabled |
| bus_oe | output | 1 | Master data-drive enable |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_cs_n | output | 1 | Active-low select for the 0x1000-0x1FFF window |

## Verification
The assertions assume reset is held across at least one rising edge, so every register starts from a known state. They also assume the request fields matter only while `req_valid` is high. They further rely on `bus_din` being settled at the falling edge of period 2. The stimulus changes requests only 1 ns after a rising edge. It moves `bus_din` only well before or well after the falling edge, which gives the data lines a stale value, a sampled value and a late value within one read. That lets a wrong capture edge show up.

// File: rtl/bus_seq_pkg.sv
`timescale 1ns/1ps
package bus_seq_pkg;
    parameter int ADDR_W = 16;
    parameter int DATA_W = 8;
    parameter int SEL_W  = 4;
    parameter logic [SEL_W-1:0] WINDOW_CODE = 4'b0001;

    localparam int SEL_LO = ADDR_W - SEL_W;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_XFER = 2'd2
    } phase_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              write;
    } bus_req_t;

    function automatic logic window_hit(input logic [ADDR_W-1:0] a,
                                        input logic [SEL_W-1:0] code);
        return a[ADDR_W-1:SEL_LO] == code;
    endfunction
endpackage

// File: rtl/bus_seq_ctrl.sv
`timescale 1ns/1ps
module bus_seq_ctrl
    import bus_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     req_valid,
    input  bus_req_t req_in,
    output phase_e   phase,
    output phase_e   phase_nxt,
    output bus_req_t cur,
    output bus_req_t cur_nxt,
    output logic     busy,
    output logic     done
);
    logic done_nxt;

    always_comb begin
        phase_nxt = phase;
        cur_nxt   = cur;
        done_nxt  = 1'b0;
        case (phase)
            PH_IDLE: if (req_valid) begin
                phase_nxt = PH_ADDR;
                cur_nxt   = req_in;
            end
            PH_ADDR: phase_nxt = PH_XFER;
            PH_XFER: begin
                phase_nxt = PH_IDLE;
                done_nxt  = 1'b1;
            end
            default: phase_nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cur   <= '0;
            done  <= 1'b0;
        end else begin
            phase <= phase_nxt;
            cur   <= cur_nxt;
            done  <= done_nxt;
        end
    end

    assign busy = (phase != PH_IDLE);

    // R3
    busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) |=> !busy)
        else $error("busy lasted more than two periods");

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cur.addr))
        else $error("address changed during an access");

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done)
        else $error("done wider than one cycle");
endmodule

// File: rtl/bus_seq_decode.sv
`timescale 1ns/1ps
module bus_seq_decode
    import bus_seq_pkg::*;
#(
    parameter logic [SEL_W-1:0] CODE = WINDOW_CODE
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    assign hit = window_hit(addr, CODE);
endmodule

// File: rtl/bus_seq_drive.sv
`timescale 1ns/1ps
module bus_seq_drive
    import bus_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase_nxt,
    input  bus_req_t          cur_nxt,
    input  logic              hit_nxt,
    output logic              rd_n,
    output logic              wr_n,
    output logic              cs_n,
    output logic              oe,
    output logic [DATA_W-1:0] dout
);
    logic xfer_nxt, active_nxt;
    assign xfer_nxt   = (phase_nxt == PH_XFER);
    assign active_nxt = (phase_nxt != PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_n <= 1'b1;
            wr_n <= 1'b1;
            cs_n <= 1'b1;
            oe   <= 1'b0;
            dout <= '0;
        end else begin
            rd_n <= !(xfer_nxt && !cur_nxt.write);
            wr_n <= !(xfer_nxt && cur_nxt.write);
            oe   <= xfer_nxt && cur_nxt.write;
            cs_n <= !(active_nxt && hit_nxt);
            dout <= (xfer_nxt && cur_nxt.write) ? cur_nxt.wdata : '0;
        end
    end

    // R7
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n))
        else $error("read and write strobes low together");

    // R6
    oe_write_chk: assert property (@(posedge clk) disable iff (rst)
        oe |-> !wr_n && rd_n)
        else $error("data driven outside write period 2");
endmodule

// File: rtl/bus_seq_capture.sv
`timescale 1ns/1ps
module bus_seq_capture
    import bus_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase,
    input  logic              is_write,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rdata
);
    always_ff @(negedge clk) begin
        if (rst)
            rdata <= '0;
        else if (phase == PH_XFER && !is_write)
            rdata <= din;
    end
endmodule

// File: rtl/bus_seq_top.sv
`timescale 1ns/1ps
module bus_seq_top
    import bus_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_write,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_oe,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic              bus_cs_n
);
    bus_req_t req_in, cur, cur_nxt;
    phase_e   phase, phase_nxt;
    logic     hit_nxt;

    assign req_in = '{addr: req_addr, wdata: req_wdata, write: req_write};

    bus_seq_ctrl u_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_in(req_in),
        .phase(phase), .phase_nxt(phase_nxt), .cur(cur), .cur_nxt(cur_nxt),
        .busy(busy), .done(done)
    );

    bus_seq_decode #(.CODE(WINDOW_CODE)) u_dec (
        .addr(cur_nxt.addr), .hit(hit_nxt)
    );

    bus_seq_drive u_drv (
        .clk(clk), .rst(rst), .phase_nxt(phase_nxt), .cur_nxt(cur_nxt),
        .hit_nxt(hit_nxt), .rd_n(bus_rd_n), .wr_n(bus_wr_n),
        .cs_n(bus_cs_n), .oe(bus_oe), .dout(bus_dout)
    );

    bus_seq_capture u_cap (
        .clk(clk), .rst(rst), .phase(phase), .is_write(cur.write),
        .din(bus_din), .rdata(rd_data)
    );

    assign bus_addr = cur.addr;

    // R8
    cs_window_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_cs_n |-> busy && bus_addr[ADDR_W-1:SEL_LO] == WINDOW_CODE)
        else $error("select outside the window");

    // R4
    rd_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rd_n |-> !bus_oe && busy)
        else $error("read strobe with data drive or while idle");

    // R7
    strobes_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> bus_rd_n && bus_wr_n)
        else $error("strobe low while idle");
endmodule

// File: tb/sim_bus_seq_top.sv
`timescale 1ns/1ps
module sim_bus_seq_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_write = 1'b0;
    logic        busy, done, bus_oe, bus_rd_n, bus_wr_n, bus_cs_n;
    logic [7:0]  rd_data, bus_dout;
    logic [7:0]  bus_din = '0;
    logic [15:0] bus_addr;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #4 clk = ~clk;

    bus_seq_top u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_write(req_write), .busy(busy),
        .done(done), .rd_data(rd_data), .bus_addr(bus_addr),
        .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
        .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_cs_n(bus_cs_n)
    );

    localparam int NV = 8;
    localparam logic        V_WR [NV] = '{0, 0, 1, 1, 0, 0, 1, 1};
    localparam logic [15:0] V_AD [NV] = '{16'h1000, 16'h0FFF, 16'h1FFF, 16'h2000,
                                          16'h1ABC, 16'hF123, 16'h1800, 16'h0000};
    localparam logic [7:0]  V_DT [NV] = '{8'h5A, 8'hC3, 8'h96, 8'h3C,
                                          8'h01, 8'hFE, 8'hFF, 8'h00};
    localparam logic        V_CS [NV] = '{1, 0, 1, 0, 1, 0, 1, 0};

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    task automatic run_access(input logic wr, input logic [15:0] a,
                              input logic [7:0] d, input logic cs_low);
        @(posedge clk); #1;
        req_valid = 1'b1; req_addr = a; req_write = wr;
        req_wdata = wr ? d : 8'h00;
        bus_din = ~d;
        @(posedge clk); #1;
        req_valid = 1'b0; req_addr = 16'hDEAD; req_wdata = 8'h77;
        #1;
        check("R3 period1 busy", busy, 1);
        check("R3 period1 addr", bus_addr, a);
        check("R4/R6 period1 rd_n", bus_rd_n, 1);
        check("R6 period1 wr_n", bus_wr_n, 1);
        check("R4/R6 period1 oe", bus_oe, 0);
        check("R8/R10 period1 cs_n", bus_cs_n, !cs_low);
        @(posedge clk); #1;
        bus_din = d;
        #1;
        check("R3 period2 busy", busy, 1);
        check("R3 period2 addr", bus_addr, a);
        check("R8/R10 period2 cs_n", bus_cs_n, !cs_low);
        check("R4 period2 rd_n", bus_rd_n, wr);
        check("R6 period2 wr_n", bus_wr_n, !wr);
        check("R6 period2 oe", bus_oe, wr);
        if (wr) check("R6 period2 dout", bus_dout, d);
        #4;
        bus_din = d ^ 8'hFF;
        @(posedge clk); #2;
        check("R9 done", done, 1);
        check("R9 busy low", busy, 0);
        check("R7 rd_n released", bus_rd_n, 1);
        check("R7 wr_n released", bus_wr_n, 1);
        check("R8 cs_n idle", bus_cs_n, 1);
        if (!wr) check("R5/R10 rd_data", rd_data, d);
        @(posedge clk); #2;
        check("R9 done single", done, 0);
    endtask

    initial begin
        #(8 * 20000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R1 rd_n", bus_rd_n, 1);
        check("R1 wr_n", bus_wr_n, 1);
        check("R1 cs_n", bus_cs_n, 1);
        check("R1 oe", bus_oe, 0);
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++)
            run_access(V_WR[i], V_AD[i], V_DT[i], V_CS[i]);

        // R2: request raised during period 1 must be dropped
        @(posedge clk); #1;
        req_valid = 1'b1; req_addr = 16'h1234; req_write = 1'b0;
        bus_din = 8'h42;
        @(posedge clk); #1;
        req_addr = 16'h5678; req_write = 1'b1; req_wdata = 8'hA5;
        @(posedge clk); #1;
        req_valid = 1'b0;
        #1;
        check("R2 addr kept", bus_addr, 16'h1234);
        check("R2 no write strobe", bus_wr_n, 1);
        check("R2 read strobe kept", bus_rd_n, 0);
        @(posedge clk); #2;
        check("R2 done", done, 1);
        check("R2 read value", rd_data, 8'h42);
        @(posedge clk); #2;
        check("R2 no extra access", busy, 0);
        check("R2 addr unchanged", bus_addr, 16'h1234);

        // R1: reset in the middle of a write
        @(posedge clk); #1;
        req_valid = 1'b1; req_addr = 16'h1100; req_write = 1'b1; req_wdata = 8'h11;
        @(posedge clk); #1;
        req_valid = 1'b0;
        @(posedge clk); #1;
        rst = 1'b1;
        @(posedge clk); #2;
        check("R1 mid reset wr_n", bus_wr_n, 1);
        check("R1 mid reset oe", bus_oe, 0);
        check("R1 mid reset cs_n", bus_cs_n, 1);
        check("R1 mid reset busy", busy, 0);
        rst = 1'b0;
        run_access(1'b0, 16'h1F00, 8'h9C, 1'b1);

        finish_run();
    end
endmodule